// File: doc/BRIEF.md
# Background Tile Shifter Pixel Pipeline

This block is the background datapath of a tile-based raster engine. Four shift registers, each twice a tile row wide, carry the next two tiles of background data. Two of them hold the low and high pattern planes. The other two hold the palette-select bits, widened so that they travel alongside the pattern bits. An external sequencer decides when data is loaded and when the registers move. It raises `reload` once every tile, with the freshly fetched pattern bytes and the 2-bit attribute present on the inputs. It holds `shift_en` high on every dot that falls in the visible or next-line prefetch window while rendering is on.

The pixel is read combinationally from the top half of the registers. A fine horizontal scroll value chooses which bit position is emitted, so the image can be scrolled by sub-tile amounts. The block can also blank the pixel in a left-edge zone that the sequencer flags. Memory fetching and palette lookup sit outside the block.

Top module: `bg_pixel_shifter`

## Requirements
- R1: While `rst_n` is low, and after it is released, every shift register is cleared, so `pix` reads 0 for any `fine_x` until data is loaded.
- R2: On a clock edge with `shift_en`=1 and `reload`=0, each of the four 16-bit registers moves one place toward bit 15, and a 0 enters bit 0.
- R3: On a clock edge with `shift_en`=0 and `reload`=0, all four registers keep their contents.
- R4: On a clock edge with `reload`=1, bits 7..0 of the low pattern register take `pat_lo_in` and bits 7..0 of the high pattern register take `pat_hi_in`. Bits 15..8 take the old bits 14..7 when `shift_en`=1, and the old bits 15..8 when `shift_en`=0.
- R5: On a clock edge with `reload`=1, bits 7..0 of the low attribute register become eight copies of `attr_in[0]`, and those of the high attribute register become eight copies of `attr_in[1]`. Bits 15..8 follow the same rule as in R4.
- R6: `pix` is {attr_hi, attr_lo, pat_hi, pat_lo}, with bit 3 first, each taken from register bit (15 − `fine_x`). It follows `fine_x` within the same cycle.
- R7: When `lmask_en`=1 and `left_zone`=1, `pix` is 0 regardless of the register contents. When either is 0, the R6 value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Shift on this dot (window and rendering already qualified) |
| reload | input | 1 | Load new tile data into the low halves |
| pat_lo_in | input | 8 | Fetched low pattern plane byte |
| pat_hi_in | input | 8 | Fetched high pattern plane byte |
| attr_in | input | 2 | Palette-select bits of the fetched tile |
| fine_x | input | 3 | Fine horizontal scroll, picks the emitted bit |
| lmask_en | input | 1 | Left-edge background mask enable |
| left_zone | input | 1 | Current dot lies in the first 8 visible pixels |
| pix | output | 4 | Background pixel {palette bits, pattern bits} |

## Verification
Register updates from `shift_en` and `reload` become visible one clock edge later. The mask and the `fine_x` selection act with no delay. The bench applies each set of inputs at the falling edge and compares `pix` a nanosecond later. At that point the register state reflects every earlier rising edge, and the current inputs reflect only the combinational path. The bench model updates its copy of the registers just before the rising edge that the DUT uses, so every comparison lines up with the cycle in which the new value is due.

// File: rtl/bg_pixel_shifter.sv
module bg_pixel_shifter #(
  parameter int TILE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift_en,
  input  logic                        reload,
  input  logic [TILE_W-1:0]           pat_lo_in,
  input  logic [TILE_W-1:0]           pat_hi_in,
  input  logic [1:0]                  attr_in,
  input  logic [$clog2(TILE_W)-1:0]   fine_x,
  input  logic                        lmask_en,
  input  logic                        left_zone,
  output logic [3:0]                  pix
);
  localparam int SH_W  = 2 * TILE_W;
  localparam int IDX_W = $clog2(SH_W);
  localparam int LANES = 4;

  logic [SH_W-1:0]   sh   [LANES];
  logic [TILE_W-1:0] fill [LANES];
  logic [IDX_W-1:0]  sel;
  logic [3:0]        raw;

  assign fill[0] = pat_lo_in;
  assign fill[1] = pat_hi_in;
  assign fill[2] = {TILE_W{attr_in[0]}};
  assign fill[3] = {TILE_W{attr_in[1]}};

  assign sel = IDX_W'(SH_W - 1) - IDX_W'(fine_x);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sh[g] <= '0;
      else if (reload)
        sh[g] <= {(shift_en ? sh[g][SH_W-2:TILE_W-1] : sh[g][SH_W-1:TILE_W]), fill[g]};
      else if (shift_en)
        sh[g] <= {sh[g][SH_W-2:0], 1'b0};
    end
    assign raw[g] = sh[g][sel];
  end

  assign pix = (lmask_en && left_zone) ? 4'd0 : {raw[3], raw[2], raw[1], raw[0]};

  // R2
  shift_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !reload) |=> (sh[0][SH_W-1:1] == $past(sh[0][SH_W-2:0])) && !sh[0][0]
                             && (sh[3][SH_W-1:1] == $past(sh[3][SH_W-2:0])));
  // R3
  hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !reload) |=> $stable(sh[0]) && $stable(sh[1]) && $stable(sh[2]) && $stable(sh[3]));
  // R4
  pat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (sh[0][TILE_W-1:0] == $past(pat_lo_in)) && (sh[1][TILE_W-1:0] == $past(pat_hi_in)));
  // R5
  attr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> ($countones(sh[2][TILE_W-1:0]) == ($past(attr_in[0]) ? TILE_W : 0))
            && ($countones(sh[3][TILE_W-1:0]) == ($past(attr_in[1]) ? TILE_W : 0)));
  // R7
  left_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lmask_en && left_zone) |-> (pix == 4'd0));
endmodule

// File: tb/test_bg_pixel_shifter.sv
module test_bg_pixel_shifter;
  logic       clk = 0, rst_n = 0;
  logic       shift_en = 0, reload = 0, lmask_en = 0, left_zone = 0;
  logic [7:0] pat_lo_in = 0, pat_hi_in = 0;
  logic [1:0] attr_in = 0;
  logic [2:0] fine_x = 0;
  logic [3:0] pix;
  int errors = 0, checks = 0;
  logic [15:0] m [4];
  bit done = 0;

  always #10 clk = ~clk;

  bg_pixel_shifter i_bg_pixel_shifter (.clk, .rst_n, .shift_en, .reload, .pat_lo_in,
    .pat_hi_in, .attr_in, .fine_x, .lmask_en, .left_zone, .pix);

  function automatic logic [3:0] exp_pix();
    int b = 15 - int'(fine_x);
    if (lmask_en && left_zone) return 4'd0;
    return {m[3][b], m[2][b], m[1][b], m[0][b]};
  endfunction

  function automatic logic [15:0] nxt(logic [15:0] v, logic [7:0] f);
    if (reload) return {(shift_en ? v[14:7] : v[15:8]), f};
    if (shift_en) return {v[14:0], 1'b0};
    return v;
  endfunction

  task automatic chk(string tag);
    logic [3:0] e = exp_pix();
    checks++;
    if (pix !== e) begin
      errors++;
      $display("FAIL %s: pix=%h expected=%h", tag, pix, e);
    end
  endtask

  task automatic step(string tag, bit se, bit rl, logic [7:0] pl, logic [7:0] ph,
                      logic [1:0] at, logic [2:0] fx, bit me, bit lz);
    @(negedge clk);
    shift_en = se; reload = rl; pat_lo_in = pl; pat_hi_in = ph; attr_in = at;
    fine_x = fx; lmask_en = me; left_zone = lz;
    #1 chk(tag);
    m[0] = nxt(m[0], pl); m[1] = nxt(m[1], ph);
    m[2] = nxt(m[2], {8{at[0]}}); m[3] = nxt(m[3], {8{at[1]}});
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1234;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    for (int f = 0; f < 8; f++) begin
      fine_x = 3'(f); #1 chk("R1 in reset");
    end
    rst_n = 1;
    for (int f = 0; f < 8; f++) step("R1 after reset", 0, 0, 8'hff, 8'hff, 2'b11, 3'(f), 0, 0);
    // R4 R5: reload without shift, then a second reload with shift
    step("R4 load1", 0, 1, 8'hA5, 8'h3C, 2'b10, 0, 0, 0);
    step("R4 load2", 1, 1, 8'h5A, 8'hC3, 2'b01, 0, 0, 0);
    // R6: sweep fine_x over the loaded data
    for (int f = 0; f < 8; f++) step("R6 fine_x sweep", 0, 0, 0, 0, 0, 3'(f), 0, 0);
    // R2: shift the tiles out
    for (int k = 0; k < 17; k++) step("R2 shift out", 1, 0, 0, 0, 0, 3'(k % 8), 0, 0);
    // R5: attribute replication, both values
    step("R5 attr 11", 0, 1, 8'h00, 8'h00, 2'b11, 0, 0, 0);
    step("R5 attr 00", 0, 1, 8'hFF, 8'h00, 2'b00, 0, 0, 0);
    for (int f = 0; f < 8; f++) step("R5 check", 0, 0, 0, 0, 0, 3'(f), 0, 0);
    // R3: hold with busy inputs
    for (int k = 0; k < 6; k++) step("R3 hold", 0, 0, 8'hFF, 8'hFF, 2'b11, 3'(k), 0, 0);
    // R7: each mask combination
    step("R7 mask on", 0, 1, 8'hFF, 8'hFF, 2'b11, 0, 1, 1);
    step("R7 mask on", 0, 0, 0, 0, 0, 0, 1, 1);
    step("R7 zone only", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R7 enable only", 0, 0, 0, 0, 0, 0, 1, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      bit rl = ($urandom % 8) == 0;
      bit se = ($urandom % 5) != 0;
      bit me = $urandom % 2;
      bit lz = ($urandom % 4) == 0;
      step("R2 R4 R6 random", se, rl, 8'($urandom), 8'($urandom), 2'($urandom),
           3'($urandom), me, lz);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule